// File: doc/BRIEF.md
# Serial Bus Node Control Register File

This block is the memory-mapped control and status register space of a node on a serial bus. A request carries a byte offset, a byte length and a read or write flag. The block walks the request one quadlet (32-bit word) per clock through consecutive register offsets. Each quadlet read produces one data beat, and each request ends with exactly one completion that carries a response code. The registers are state (separate set and clear offsets), node ID, the split-timeout pair, cycle time, bus time, the broadcast channel, and read-only views of the resource registers. Each register has its own write mask and its own access rule.

Bus time is extended in hardware. Whenever cycle time or bus time is read, the block samples an external cycle counter. If the new sample is below the previous one, the counter has wrapped, and the seconds field of bus time is advanced. The split-timeout pair is converted into a timeout expressed in timer ticks. This value is recomputed on every write to either half and is driven on a port. A bus-reset event input reloads the node ID from the physical layer, trims the state register and restores the broadcast channel.

Top module: `sbus_csr_file`

## Requirements
- R1: A request whose offset or byte length is not a multiple of 4, or whose length is 0, completes one clock after acceptance with code 1 (type error). It produces no beat and changes no register.
- R2: A quadlet at an unmapped offset, or at the busy-timeout offset 0x210, ends the request with code 2 (address error). Quadlets before it in the same request still take effect.
- R3: Split-timeout-high (0x018) keeps only bits [2:0], and split-timeout-low (0x01C) keeps only bits [31:19]. After reset they read 0 and 0x19000000.
- R4: The split_expire port equals ((high[2:0]<<13 + low>>19) * TICK_HZ) >> 13, plus 1. It is updated at the clock edge of a write to either half. With TICK_HZ=100 the reset value is 10.
- R5: A read of cycle time (0x200) returns cycle_count. A read of cycle time or bus time whose sample is below the previously stored cycle time adds 128 to bus time. A write to cycle time replaces the stored previous sample.
- R6: A read of bus time (0x204) returns stored bus time ORed with cycle_count[31:25]. A write to bus time keeps only bits [31:7].
- R7: The broadcast channel (0x234) reads 0x8000001F after reset. A write changes only bit 30.
- R8: A node-ID write (0x008) replaces bits [31:22] and keeps bits [21:16]. Bits [15:0] read 0. The node_id port shows bits [31:16]. A bus reset loads bits [31:16] from phy_node_id.
- R9: A read of reset-start (0x00C) gives code 1, and a write to it completes with code 0 and no effect. Writes to the resource registers (0x21C, 0x220, 0x224, 0x228) give code 1. Reads of them return 0x3F, 4915, 0xFFFFFFFE and 0xFFFFFFFF.
- R10: The state register resets to 0. A write to 0x004 ORs the data in, and a write to 0x000 clears the bits that are set in the data. Both offsets read the state.
- R11: A bus reset keeps only state bits [9:8], clears bit 8 when node_is_root is 0, and restores the broadcast channel to 0x8000001F.
- R12: A request of N quadlets handles offsets off, off+4, and so on, one per clock. Each read quadlet gives one beat, and a completion with code 0 follows the last quadlet.
- R13: After reset, busy, beat_valid and done_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when busy is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Byte offset of the first quadlet |
| req_len | input | LEN_W | Request length in bytes |
| wr_data | input | 32 | Write data for the quadlet handled in the current cycle |
| cycle_count | input | 32 | External cycle counter |
| bus_reset_evt | input | 1 | One-cycle bus reset event |
| node_is_root | input | 1 | Node is root at the bus reset |
| phy_node_id | input | 16 | Node ID loaded at a bus reset |
| busy | output | 1 | A request is in progress |
| beat_valid | output | 1 | beat_data holds one read quadlet |
| beat_data | output | 32 | Read data |
| done_valid | output | 1 | Request completion |
| done_code | output | 2 | 0 complete, 1 type error, 2 address error |
| node_id | output | 16 | Current node ID |
| split_expire | output | EXP_W | Split timeout in timer ticks |

## Verification
A request is accepted at a rising edge. The quadlet at index k is handled in the cycle that follows the k-th edge after acceptance. Its beat, its register update and any change on node_id or split_expire appear at the next edge. The completion appears at the same edge as the last quadlet, and for a misaligned request it appears at the first edge after acceptance. The bench drives write data for each quadlet in the falling-edge half of the cycle in which it is consumed. A monitor reads the outputs at every falling edge and pops a queue of expected beats and completions in order. Port values are checked at the falling edge on which the completion is seen.

// File: rtl/sbus_csr_pkg.sv
`timescale 1ns/1ps
package sbus_csr_pkg;

  typedef enum logic [1:0] {
    RSP_DONE     = 2'd0,
    RSP_TYPE_ERR = 2'd1,
    RSP_ADDR_ERR = 2'd2
  } rsp_e;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_ST_CLR,
    REG_ST_SET,
    REG_NODE,
    REG_RST_START,
    REG_SPLIT_HI,
    REG_SPLIT_LO,
    REG_CYCLE,
    REG_BUSTIME,
    REG_BUSY_TO,
    REG_BM_ID,
    REG_BW,
    REG_CH_HI,
    REG_CH_LO,
    REG_BCAST
  } reg_e;

  // byte offsets inside the register space
  localparam int OFF_ST_CLR      = 'h000;
  localparam int OFF_ST_SET      = 'h004;
  localparam int OFF_NODE        = 'h008;
  localparam int OFF_RST_START   = 'h00C;
  localparam int OFF_SPLIT_HI    = 'h018;
  localparam int OFF_SPLIT_LO    = 'h01C;
  localparam int OFF_CYCLE       = 'h200;
  localparam int OFF_BUSTIME     = 'h204;
  localparam int OFF_BUSY_TO     = 'h210;
  localparam int OFF_BM_ID       = 'h21C;
  localparam int OFF_BW          = 'h220;
  localparam int OFF_CH_HI       = 'h224;
  localparam int OFF_CH_LO       = 'h228;
  localparam int OFF_BCAST       = 'h234;

  localparam logic [31:0] BM_ID_VAL  = 32'h0000_003F;
  localparam logic [31:0] BW_VAL     = 32'd4915;
  localparam logic [31:0] CH_HI_VAL  = 32'hFFFF_FFFE;
  localparam logic [31:0] CH_LO_VAL  = 32'hFFFF_FFFF;
  localparam logic [12:0] SPLIT_LO_RST = 13'd800;

endpackage

// File: rtl/sbus_csr_decode.sv
`timescale 1ns/1ps
module sbus_csr_decode
  import sbus_csr_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic              is_write,
  output reg_e              sel,
  output rsp_e              code
);

  always_comb begin
    sel = REG_NONE;
    case (offset)
      ADDR_W'(OFF_ST_CLR):    sel = REG_ST_CLR;
      ADDR_W'(OFF_ST_SET):    sel = REG_ST_SET;
      ADDR_W'(OFF_NODE):      sel = REG_NODE;
      ADDR_W'(OFF_RST_START): sel = REG_RST_START;
      ADDR_W'(OFF_SPLIT_HI):  sel = REG_SPLIT_HI;
      ADDR_W'(OFF_SPLIT_LO):  sel = REG_SPLIT_LO;
      ADDR_W'(OFF_CYCLE):     sel = REG_CYCLE;
      ADDR_W'(OFF_BUSTIME):   sel = REG_BUSTIME;
      ADDR_W'(OFF_BUSY_TO):   sel = REG_BUSY_TO;
      ADDR_W'(OFF_BM_ID):     sel = REG_BM_ID;
      ADDR_W'(OFF_BW):        sel = REG_BW;
      ADDR_W'(OFF_CH_HI):     sel = REG_CH_HI;
      ADDR_W'(OFF_CH_LO):     sel = REG_CH_LO;
      ADDR_W'(OFF_BCAST):     sel = REG_BCAST;
      default:                sel = REG_NONE;
    endcase
  end

  always_comb begin
    case (sel)
      REG_NONE, REG_BUSY_TO:            code = RSP_ADDR_ERR;
      REG_RST_START:                    code = is_write ? RSP_DONE : RSP_TYPE_ERR;
      REG_BM_ID, REG_BW,
      REG_CH_HI, REG_CH_LO:             code = is_write ? RSP_TYPE_ERR : RSP_DONE;
      default:                          code = RSP_DONE;
    endcase
  end

endmodule

// File: rtl/sbus_csr_timebase.sv
`timescale 1ns/1ps
module sbus_csr_timebase (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_en,
  input  logic [31:0] cyc_in,
  input  logic        cyc_wr_en,
  input  logic        bus_wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_cycle,
  output logic [31:0] rd_bus
);

  logic [31:0] cyc_q, cyc_nxt;
  logic [24:0] bus_q, bus_nxt, bus_now;
  logic        wrap, cyc_en, bus_en;

  always_comb begin
    wrap     = sample_en && (cyc_in < cyc_q);
    bus_now  = wrap ? bus_q + 25'd1 : bus_q;
    bus_nxt  = bus_wr_en ? wr_data[31:7] : bus_now;
    bus_en   = bus_wr_en | wrap;
    cyc_nxt  = cyc_wr_en ? wr_data : cyc_in;
    cyc_en   = cyc_wr_en | sample_en;
    rd_cycle = cyc_in;
    rd_bus   = {bus_now, 7'b0} | {25'b0, cyc_in[31:25]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      bus_q <= '0;
    end else begin
      if (cyc_en) cyc_q <= cyc_nxt;
      if (bus_en) bus_q <= bus_nxt;
    end
  end

  // R5
  wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !bus_wr_en && (cyc_in < cyc_q)) |=> (bus_q == $past(bus_q) + 25'd1));

  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !bus_wr_en) |=> $stable(bus_q));

  // R5
  cyc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !cyc_wr_en) |=> (cyc_q == $past(cyc_in)));

endmodule

// File: rtl/sbus_csr_split.sv
`timescale 1ns/1ps
module sbus_csr_split
  import sbus_csr_pkg::*;
#(
  parameter int TICK_HZ = 100,
  parameter int EXP_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [2:0]       hi_in,
  input  logic [12:0]      lo_in,
  output logic [31:0]      rd_hi,
  output logic [31:0]      rd_lo,
  output logic [EXP_W-1:0] expire
);

  localparam int UNIT_W = 16;
  localparam int PROD_W = UNIT_W + $clog2(TICK_HZ + 1);

  function automatic logic [EXP_W-1:0] calc_expire(input logic [2:0] h, input logic [12:0] l);
    logic [PROD_W-1:0] units;
    logic [PROD_W-1:0] prod;
    units = PROD_W'({h, 13'b0}) + PROD_W'(l);
    prod  = units * PROD_W'(TICK_HZ);
    return EXP_W'((prod >> 13) + PROD_W'(1));
  endfunction

  localparam logic [EXP_W-1:0] EXP_RST = calc_expire(3'd0, SPLIT_LO_RST);

  logic [2:0]       hi_q, hi_nxt;
  logic [12:0]      lo_q, lo_nxt;
  logic [EXP_W-1:0] exp_q, exp_nxt;
  logic             upd_en;

  always_comb begin
    hi_nxt  = wr_hi ? hi_in : hi_q;
    lo_nxt  = wr_lo ? lo_in : lo_q;
    upd_en  = wr_hi | wr_lo;
    exp_nxt = calc_expire(hi_nxt, lo_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= SPLIT_LO_RST;
      exp_q <= EXP_RST;
    end else if (upd_en) begin
      hi_q  <= hi_nxt;
      lo_q  <= lo_nxt;
      exp_q <= exp_nxt;
    end
  end

  assign rd_hi  = {29'b0, hi_q};
  assign rd_lo  = {lo_q, 19'b0};
  assign expire = exp_q;

  // R4
  expire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hi || wr_lo) |=> $stable(expire));

  // R3
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (rd_hi == {29'b0, $past(hi_in)}));

endmodule

// File: rtl/sbus_csr_file.sv
`timescale 1ns/1ps
module sbus_csr_file
  import sbus_csr_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LEN_W   = 8,
  parameter int TICK_HZ = 100,
  parameter int EXP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       cycle_count,
  input  logic              bus_reset_evt,
  input  logic              node_is_root,
  input  logic [15:0]       phy_node_id,
  output logic              busy,
  output logic              beat_valid,
  output logic [31:0]       beat_data,
  output logic              done_valid,
  output logic [1:0]        done_code,
  output logic [15:0]       node_id,
  output logic [EXP_W-1:0]  split_expire
);

  localparam int CNT_W = LEN_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // sequencer state
  logic              busy_q, busy_nxt;
  logic [ADDR_W-1:0] off_q, off_nxt;
  logic [CNT_W-1:0]  left_q, left_nxt;
  logic              wr_q, wr_nxt;
  logic              bv_q, bv_nxt;
  logic [31:0]       bd_q, bd_nxt;
  logic              dv_q, dv_nxt;
  rsp_e              dc_q, dc_nxt;
  logic              seq_en;

  logic              accept, misfit, beat_ok, we, re;
  reg_e              cur_sel;
  rsp_e              cur_code;
  logic [31:0]       rd_word;

  // register state
  logic [31:0] state_q, state_nxt;
  logic        state_en;
  logic [15:0] node_q, node_nxt;
  logic        node_en;
  logic        bc_valid_q, bc_valid_nxt;
  logic        bc_en;

  logic [31:0] rd_cycle, rd_bus, rd_hi, rd_lo;

  sbus_csr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .offset   (off_q),
    .is_write (wr_q),
    .sel      (cur_sel),
    .code     (cur_code)
  );

  always_comb begin
    misfit  = (req_offset[1:0] != 2'b00) || (req_len[1:0] != 2'b00) ||
              (req_len[LEN_W-1:2] == '0);
    accept  = req_valid && !busy_q;
    beat_ok = busy_q && (cur_code == RSP_DONE);
    we      = beat_ok && wr_q;
    re      = beat_ok && !wr_q;
  end

  sbus_csr_timebase u_timebase (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sample_en (re && ((cur_sel == REG_CYCLE) || (cur_sel == REG_BUSTIME))),
    .cyc_in    (cycle_count),
    .cyc_wr_en (we && (cur_sel == REG_CYCLE)),
    .bus_wr_en (we && (cur_sel == REG_BUSTIME)),
    .wr_data   (wr_data),
    .rd_cycle  (rd_cycle),
    .rd_bus    (rd_bus)
  );

  sbus_csr_split #(.TICK_HZ(TICK_HZ), .EXP_W(EXP_W)) u_split (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_hi  (we && (cur_sel == REG_SPLIT_HI)),
    .wr_lo  (we && (cur_sel == REG_SPLIT_LO)),
    .hi_in  (wr_data[2:0]),
    .lo_in  (wr_data[31:19]),
    .rd_hi  (rd_hi),
    .rd_lo  (rd_lo),
    .expire (split_expire)
  );

  // read multiplexer
  always_comb begin
    case (cur_sel)
      REG_ST_CLR, REG_ST_SET: rd_word = state_q;
      REG_NODE:               rd_word = {node_q, 16'h0000};
      REG_SPLIT_HI:           rd_word = rd_hi;
      REG_SPLIT_LO:           rd_word = rd_lo;
      REG_CYCLE:              rd_word = rd_cycle;
      REG_BUSTIME:            rd_word = rd_bus;
      REG_BM_ID:              rd_word = BM_ID_VAL;
      REG_BW:                 rd_word = BW_VAL;
      REG_CH_HI:              rd_word = CH_HI_VAL;
      REG_CH_LO:              rd_word = CH_LO_VAL;
      REG_BCAST:              rd_word = {1'b1, bc_valid_q, 24'h0, 6'h1F};
      default:                rd_word = 32'h0;
    endcase
  end

  // sequencer next state
  always_comb begin
    busy_nxt = busy_q;
    off_nxt  = off_q;
    left_nxt = left_q;
    wr_nxt   = wr_q;
    bv_nxt   = 1'b0;
    bd_nxt   = bd_q;
    dv_nxt   = 1'b0;
    dc_nxt   = dc_q;
    if (busy_q) begin
      if (cur_code != RSP_DONE) begin
        dv_nxt   = 1'b1;
        dc_nxt   = cur_code;
        busy_nxt = 1'b0;
      end else begin
        if (!wr_q) begin
          bv_nxt = 1'b1;
          bd_nxt = rd_word;
        end
        if (left_q == CNT_W'(1)) begin
          dv_nxt   = 1'b1;
          dc_nxt   = RSP_DONE;
          busy_nxt = 1'b0;
        end else begin
          off_nxt  = off_q + ADDR_W'(4);
          left_nxt = left_q - CNT_W'(1);
        end
      end
    end else if (accept) begin
      if (misfit) begin
        dv_nxt = 1'b1;
        dc_nxt = RSP_TYPE_ERR;
      end else begin
        busy_nxt = 1'b1;
        off_nxt  = req_offset;
        left_nxt = req_len[LEN_W-1:2];
        wr_nxt   = req_write;
      end
    end
    seq_en = busy_q | accept;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      busy_q <= 1'b0;
      off_q  <= '0;
      left_q <= '0;
      wr_q   <= 1'b0;
      bv_q   <= 1'b0;
      bd_q   <= '0;
      dv_q   <= 1'b0;
      dc_q   <= RSP_DONE;
    end else begin
      bv_q <= bv_nxt;
      dv_q <= dv_nxt;
      if (seq_en) begin
        busy_q <= busy_nxt;
        off_q  <= off_nxt;
        left_q <= left_nxt;
        wr_q   <= wr_nxt;
        bd_q   <= bd_nxt;
        dc_q   <= dc_nxt;
      end
    end
  end

  // register file next state
  always_comb begin
    state_en  = bus_reset_evt || (we && ((cur_sel == REG_ST_SET) || (cur_sel == REG_ST_CLR)));
    if (bus_reset_evt)
      state_nxt = state_q & (node_is_root ? 32'h0000_0300 : 32'h0000_0200);
    else if (cur_sel == REG_ST_SET)
      state_nxt = state_q | wr_data;
    else
      state_nxt = state_q & ~wr_data;

    node_en  = bus_reset_evt || (we && (cur_sel == REG_NODE));
    node_nxt = bus_reset_evt ? phy_node_id : {wr_data[31:22], node_q[5:0]};

    bc_en        = bus_reset_evt || (we && (cur_sel == REG_BCAST));
    bc_valid_nxt = bus_reset_evt ? 1'b0 : wr_data[30];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q    <= '0;
      node_q     <= '0;
      bc_valid_q <= 1'b0;
    end else begin
      if (state_en) state_q    <= state_nxt;
      if (node_en)  node_q     <= node_nxt;
      if (bc_en)    bc_valid_q <= bc_valid_nxt;
    end
  end

  assign busy       = busy_q;
  assign beat_valid = bv_q;
  assign beat_data  = bd_q;
  assign done_valid = dv_q;
  assign done_code  = dc_q;
  assign node_id    = node_q;

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    dv_q |-> !busy_q);

  // R12
  beat_src_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy_q && !wr_q && (cur_code == RSP_DONE)) |=> bv_q);

  // R1
  misfit_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && misfit) |=> (dv_q && (dc_q == RSP_TYPE_ERR) && !busy_q && !bv_q));

  // R11
  cmstr_drop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_reset_evt && !node_is_root) |=> !state_q[8]);

  // R8
  node_field_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bus_reset_evt |=> (node_q[5:0] == $past(node_q[5:0])));

  // R7
  bcast_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!bus_reset_evt && !(we && (cur_sel == REG_BCAST))) |=> $stable(bc_valid_q));

endmodule

// File: tb/tb_sbus_csr_file.sv
`timescale 1ns/1ps
module tb_sbus_csr_file;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] C_OK   = 2'd0;
  localparam logic [1:0] C_TYPE = 2'd1;
  localparam logic [1:0] C_ADDR = 2'd2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [9:0]  req_offset;
  logic [7:0]  req_len;
  logic [31:0] wr_data;
  logic [31:0] cycle_count;
  logic        bus_reset_evt;
  logic        node_is_root;
  logic [15:0] phy_node_id;
  logic        busy;
  logic        beat_valid;
  logic [31:0] beat_data;
  logic        done_valid;
  logic [1:0]  done_code;
  logic [15:0] node_id;
  logic [31:0] split_expire;

  sbus_csr_file dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_offset    (req_offset),
    .req_len       (req_len),
    .wr_data       (wr_data),
    .cycle_count   (cycle_count),
    .bus_reset_evt (bus_reset_evt),
    .node_is_root  (node_is_root),
    .phy_node_id   (phy_node_id),
    .busy          (busy),
    .beat_valid    (beat_valid),
    .beat_data     (beat_data),
    .done_valid    (done_valid),
    .done_code     (done_code),
    .node_id       (node_id),
    .split_expire  (split_expire)
  );

  typedef struct packed {
    logic        is_done;
    logic [31:0] data;
    logic [1:0]  code;
    logic [7:0]  req;
  } item_t;

  item_t exp_q[$];
  item_t mon_it;
  int    checks = 0;
  int    errors = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic expect_beat(input int r, input logic [31:0] d);
    exp_q.push_back('{is_done: 1'b0, data: d, code: 2'd0, req: 8'(r)});
  endtask

  task automatic expect_done(input int r, input logic [1:0] c);
    exp_q.push_back('{is_done: 1'b1, data: 32'h0, code: c, req: 8'(r)});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (beat_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12: actual unexpected beat %h expected nothing", beat_data);
        end else begin
          mon_it = exp_q.pop_front();
          if (mon_it.is_done) begin
            checks++; errors++;
            $display("FAIL R%0d: actual beat %h expected completion", mon_it.req, beat_data);
          end else chk(int'(mon_it.req), beat_data, mon_it.data);
        end
      end
      if (done_valid) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12: actual unexpected completion %0d expected nothing", done_code);
        end else begin
          mon_it = exp_q.pop_front();
          if (!mon_it.is_done) begin
            checks++; errors++;
            $display("FAIL R%0d: actual completion %0d expected beat %h", mon_it.req, done_code, mon_it.data);
          end else chk(int'(mon_it.req), {30'b0, done_code}, {30'b0, mon_it.code});
        end
      end
    end
  end

  task automatic run(input bit w, input int off, input int len,
                     input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] words [3];
    int k;
    words[0] = d0; words[1] = d1; words[2] = d2;
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = w;
    req_offset = off[9:0];
    req_len    = len[7:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0;
    while (!done_valid) begin
      wr_data = words[(k < 3) ? k : 2];
      @(posedge clk);
      @(negedge clk);
      k++;
    end
  endtask

  task automatic rd(input int off, input int len);
    run(1'b0, off, len, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic wr(input int off, input logic [31:0] d);
    run(1'b1, off, 4, d, 32'h0, 32'h0);
  endtask

  task automatic pulse_bus_reset(input logic root, input logic [15:0] id);
    @(negedge clk);
    node_is_root  = root;
    phy_node_id   = id;
    bus_reset_evt = 1'b1;
    @(negedge clk);
    bus_reset_evt = 1'b0;
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12: watchdog actual still running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_offset = '0; req_len = '0;
    wr_data = '0; cycle_count = '0; bus_reset_evt = 1'b0; node_is_root = 1'b0; phy_node_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R13 reset state of the ports
    chk(13, {31'b0, busy}, 32'h0);
    chk(13, {31'b0, beat_valid}, 32'h0);
    chk(13, {31'b0, done_valid}, 32'h0);
    chk(8, {16'h0, node_id}, 32'h0);
    chk(4, split_expire, 32'd10);           // R4 reset expiry

    // R3 R12 split pair reset values through a two-quadlet read
    expect_beat(3, 32'h0); expect_beat(3, 32'h1900_0000); expect_done(12, C_OK);
    rd('h018, 8);

    // R3 R4 masked writes and expiry update
    expect_done(3, C_OK); wr('h018, 32'hFFFF_FFF9);
    chk(4, split_expire, 32'd110);
    expect_done(3, C_OK); wr('h01C, 32'hFFFF_FFFF);
    chk(4, split_expire, 32'd200);
    expect_beat(3, 32'h1); expect_beat(3, 32'hFFF8_0000); expect_done(12, C_OK);
    rd('h018, 8);

    // R1 misaligned offset, odd length, zero length, misaligned write
    expect_done(1, C_TYPE); rd('h002, 4);
    expect_done(1, C_TYPE); rd('h000, 6);
    expect_done(1, C_TYPE); rd('h018, 0);
    expect_done(1, C_TYPE); run(1'b1, 'h01A, 4, 32'h0, 32'h0, 32'h0);
    expect_beat(1, 32'h1); expect_done(1, C_OK); rd('h018, 4);
    chk(1, split_expire, 32'd200);

    // R2 gaps and busy timeout
    expect_done(2, C_ADDR); rd('h100, 4);
    expect_done(2, C_ADDR); rd('h210, 4);
    expect_done(2, C_ADDR); wr('h210, 32'h1);
    expect_beat(2, 32'hFFF8_0000); expect_done(2, C_ADDR); rd('h01C, 8);
    expect_done(2, C_ADDR); run(1'b1, 'h018, 12, 32'h2, 32'h0, 32'h5);
    chk(2, split_expire, 32'd201);
    expect_beat(2, 32'h2); expect_beat(2, 32'h0); expect_done(2, C_OK); rd('h018, 8);

    // R9 reset-start and resource registers
    expect_done(9, C_TYPE); rd('h00C, 4);
    expect_done(9, C_OK);   wr('h00C, 32'hFFFF_FFFF);
    expect_done(9, C_TYPE); wr('h21C, 32'h0);
    expect_done(9, C_TYPE); wr('h220, 32'h0);
    expect_done(9, C_TYPE); wr('h224, 32'h0);
    expect_done(9, C_TYPE); wr('h228, 32'h0);
    expect_beat(9, 32'h3F); expect_beat(9, 32'd4915);
    expect_beat(9, 32'hFFFF_FFFE); expect_beat(9, 32'hFFFF_FFFF); expect_done(12, C_OK);
    rd('h21C, 16);

    // R5 R6 cycle time, bus time and wrap detection
    cycle_count = 32'h0000_1000;
    expect_beat(5, 32'h0000_1000); expect_done(5, C_OK); rd('h200, 4);
    cycle_count = 32'h0000_0800;
    expect_beat(5, 32'h0000_0080); expect_done(5, C_OK); rd('h204, 4);
    cycle_count = 32'hFE00_0010;
    expect_beat(6, 32'h0000_00FF); expect_done(6, C_OK); rd('h204, 4);
    expect_done(6, C_OK); wr('h204, 32'h1234_5678);
    cycle_count = 32'h0200_0000;
    expect_beat(6, 32'h1234_5681); expect_done(6, C_OK); rd('h204, 4);
    expect_done(5, C_OK); wr('h200, 32'h0000_0005);
    cycle_count = 32'h0000_0003;
    expect_beat(5, 32'h0000_0003); expect_done(5, C_OK); rd('h200, 4);
    expect_beat(5, 32'h1234_5700); expect_done(5, C_OK); rd('h204, 4);
    cycle_count = 32'h0400_0000;
    expect_beat(12, 32'h0400_0000); expect_beat(12, 32'h1234_5702); expect_done(12, C_OK);
    rd('h200, 8);

    // R7 broadcast channel
    expect_beat(7, 32'h8000_001F); expect_done(7, C_OK); rd('h234, 4);
    expect_done(7, C_OK); wr('h234, 32'hFFFF_FFFF);
    expect_beat(7, 32'hC000_001F); expect_done(7, C_OK); rd('h234, 4);

    // R10 state set and clear
    expect_beat(10, 32'h0); expect_done(10, C_OK); rd('h000, 4);
    expect_done(10, C_OK); wr('h004, 32'h0000_0301);
    expect_beat(10, 32'h0000_0301); expect_done(10, C_OK); rd('h000, 4);
    expect_done(10, C_OK); wr('h000, 32'h0000_0001);
    expect_beat(10, 32'h0000_0300); expect_done(10, C_OK); rd('h004, 4);
    expect_done(10, C_OK); wr('h004, 32'h0000_00F0);

    // R11 R8 bus reset as non-root
    pulse_bus_reset(1'b0, 16'h0005);
    @(negedge clk);
    chk(8, {16'h0, node_id}, 32'h0000_0005);
    expect_beat(11, 32'h0000_0200); expect_done(11, C_OK); rd('h000, 4);
    expect_beat(11, 32'h8000_001F); expect_done(11, C_OK); rd('h234, 4);
    expect_beat(8, 32'h0005_0000); expect_done(8, C_OK); rd('h008, 4);

    // R11 bus reset as root keeps the cycle-master bit
    expect_done(10, C_OK); wr('h004, 32'h0000_0100);
    pulse_bus_reset(1'b1, 16'h0007);
    @(negedge clk);
    expect_beat(11, 32'h0000_0300); expect_done(11, C_OK); rd('h000, 4);

    // R8 node-ID write replaces only the bus field
    expect_done(8, C_OK); wr('h008, 32'hFFC3_1234);
    chk(8, {16'h0, node_id}, 32'h0000_FFC7);
    expect_beat(8, 32'hFFC7_0000); expect_done(8, C_OK); rd('h008, 4);

    // R12 multi-quadlet write then read across state and node
    expect_done(12, C_OK); run(1'b1, 'h000, 12, 32'h0000_0300, 32'h0000_0005, 32'h0040_0000);
    chk(12, {16'h0, node_id}, 32'h0000_0047);
    expect_beat(12, 32'h5); expect_beat(12, 32'h5); expect_beat(12, 32'h0047_0000);
    expect_done(12, C_OK);
    rd('h000, 12);

    repeat (3) @(negedge clk);
    chk(12, exp_q.size(), 32'h0);   // R12 every expected item arrived
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule